// File: doc/BRIEF.md
# Per-Node Status and Interrupt Flag Bank

This block is the status corner of a bus master that polls up to 64 remote nodes. For every node it keeps an 8-bit information byte and a single cyclic-error flag. It also keeps four input-change interrupt flags, one per port, each paired with an enable bit. A CPU reaches all of this through a 9-bit byte address, a select strobe and a write strobe. Reads are combinational and take effect in the same cycle. Writes take effect at the clock edge on which both strobes are high.

The flags are set by hardware event inputs, one per flag. Software never sets a flag. It acknowledges flags by writing a mask to the same byte it reads them from, and every 1 in that mask clears the matching flag. The enable bytes are plain storage. The information bytes are also plain storage. An active-low interrupt request is asserted whenever a change flag is set and its enable bit is set too.

The byte locations are fixed because driver software decodes them. Any address outside the four areas, including the unused window 008h to 077h, reads as 00h and ignores writes.

Top module: `nodestat_bank`

## Requirements
- R1: After reset every information byte, error flag, change enable and change flag is 0, and irq_n is 1.
- R2: The information byte of node n sits at address 078h+n, for n from 0 to 63. A write stores the byte, and a read returns it.
- R3: The error flag of node n is bit (n mod 8) of the byte at 0B8h+(n div 8). A 1 on err_set[n] at a clock edge sets that flag.
- R4: The change enables of nodes 2k and 2k+1 share the byte at 0C0h+k. Bits 3:0 hold ports 0 to 3 of the even node, and bits 7:4 hold ports 0 to 3 of the odd node. The byte can be written and read back.
- R5: The change flags use the same packing in the bytes at 0E0h+k. A 1 on chg_set[4*n+p] at a clock edge sets the flag for node n, port p.
- R6: A write to an error byte or a change-flag byte clears exactly the flags whose written bit is 1. Bits written as 0 leave their flags unchanged.
- R7: When a set input and a clearing write hit the same flag at the same edge, the flag ends up set.
- R8: irq_n is 0 exactly when at least one change flag is set and its enable bit is also set.
- R9: Addresses outside the four areas read as 00h. This includes 000h to 077h and 100h to 1FFh. Writes to these addresses change no stored bit.
- R10: Reading a flag byte does not change any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when no read is selected |
| err_set | input | NODES | Per-node error set pulses |
| chg_set | input | 4*NODES | Per-port input-change set pulses, index 4*node+port |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Two functions can land on the same flag in the same cycle: a hardware set pulse and a CPU acknowledge write. The bench provokes this by raising chg_set or err_set during the very cycle in which it writes a clearing mask to that flag's byte. It then reads the byte back and expects the bit still set. It also expects irq_n to stay low while the enable bit is set. A neighbouring bit that is cleared in the same write must still drop to 0, which proves that the clear itself took effect.

// File: rtl/nodestat_pkg.sv
package nodestat_pkg;

  localparam int ADDR_W = 9;
  localparam int BYTE_W = 8;
  localparam int PORTS  = 4;
  localparam int IDX_W  = 6;

  localparam int INFO_BASE = 'h078;
  localparam int ERR_BASE  = 'h0B8;
  localparam int IEN_BASE  = 'h0C0;
  localparam int IFLG_BASE = 'h0E0;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_INFO,
    RG_ERR,
    RG_IEN,
    RG_IFLG
  } region_e;

  typedef struct packed {
    region_e           region;
    logic [IDX_W-1:0]  idx;
  } hit_t;

  // Maps a byte address to an area and a byte index inside that area.
  function automatic hit_t decode_addr(input logic [ADDR_W-1:0] a, input int nodes);
    hit_t h;
    int   ai;
    ai       = int'(a);
    h.region = RG_NONE;
    h.idx    = '0;
    if (ai >= INFO_BASE && ai < INFO_BASE + nodes) begin
      h.region = RG_INFO;
      h.idx    = IDX_W'(ai - INFO_BASE);
    end else if (ai >= ERR_BASE && ai < ERR_BASE + nodes / 8) begin
      h.region = RG_ERR;
      h.idx    = IDX_W'(ai - ERR_BASE);
    end else if (ai >= IEN_BASE && ai < IEN_BASE + nodes / 2) begin
      h.region = RG_IEN;
      h.idx    = IDX_W'(ai - IEN_BASE);
    end else if (ai >= IFLG_BASE && ai < IFLG_BASE + nodes / 2) begin
      h.region = RG_IFLG;
      h.idx    = IDX_W'(ai - IFLG_BASE);
    end
    return h;
  endfunction

  // Flat position of a change flag: ports of one node are adjacent.
  function automatic int chg_bit(input int node, input int port);
    return node * PORTS + port;
  endfunction

  // Next value of a sticky flag: a set beats a clear.
  function automatic logic flag_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

endpackage

// File: rtl/nodestat_decode.sv
module nodestat_decode
  import nodestat_pkg::*;
#(
  parameter int NODES = 64
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx,
  output logic [NODES-1:0]  info_wr,
  output logic [NODES/8-1:0] err_clr_byte,
  output logic [NODES/2-1:0] ien_wr,
  output logic [NODES/2-1:0] iflg_clr_byte
);

  localparam int ERR_BYTES  = NODES / 8;
  localparam int PAIR_BYTES = NODES / 2;

  hit_t hit;
  logic wr_act;

  assign hit    = decode_addr(bus_addr, NODES);
  assign region = hit.region;
  assign idx    = hit.idx;
  assign wr_act = bus_sel & bus_wr;

  for (genvar k = 0; k < NODES; k++) begin : g_info
    assign info_wr[k] = wr_act && (hit.region == RG_INFO) && (hit.idx == IDX_W'(k));
  end

  for (genvar k = 0; k < ERR_BYTES; k++) begin : g_err
    assign err_clr_byte[k] = wr_act && (hit.region == RG_ERR) && (hit.idx == IDX_W'(k));
  end

  for (genvar k = 0; k < PAIR_BYTES; k++) begin : g_pair
    assign ien_wr[k]        = wr_act && (hit.region == RG_IEN)  && (hit.idx == IDX_W'(k));
    assign iflg_clr_byte[k] = wr_act && (hit.region == RG_IFLG) && (hit.idx == IDX_W'(k));
  end

endmodule

// File: rtl/nodestat_flags.sv
module nodestat_flags
  import nodestat_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= flag_next(q[i], set_i[i], clr_i[i]);
    end
  end

endmodule

// File: rtl/nodestat_bytereg.sv
module nodestat_bytereg
  import nodestat_pkg::*;
#(
  parameter int BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BYTES-1:0]        wr_i,
  input  logic [BYTE_W-1:0]       wdata_i,
  output logic [BYTES*BYTE_W-1:0] q
);

  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[k*BYTE_W +: BYTE_W] <= '0;
      else if (wr_i[k]) q[k*BYTE_W +: BYTE_W] <= wdata_i;
    end
  end

endmodule

// File: rtl/nodestat_bank.sv
module nodestat_bank
  import nodestat_pkg::*;
#(
  parameter int NODES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [BYTE_W-1:0]      bus_wdata,
  output logic [BYTE_W-1:0]      bus_rdata,
  input  logic [NODES-1:0]       err_set,
  input  logic [NODES*PORTS-1:0] chg_set,
  output logic                   irq_n
);

  localparam int ERR_BYTES  = NODES / 8;
  localparam int PAIR_BYTES = NODES / 2;
  localparam int CHG_W      = NODES * PORTS;

  region_e                    region;
  logic [IDX_W-1:0]           idx;
  logic [NODES-1:0]           info_wr;
  logic [ERR_BYTES-1:0]       err_clr_byte;
  logic [PAIR_BYTES-1:0]      ien_wr;
  logic [PAIR_BYTES-1:0]      iflg_clr_byte;

  logic [NODES*BYTE_W-1:0]    info_q;
  logic [NODES-1:0]           err_q;
  logic [NODES-1:0]           err_clr;
  logic [CHG_W-1:0]           ien_q;
  logic [CHG_W-1:0]           iflg_q;
  logic [CHG_W-1:0]           iflg_clr;
  logic                       ien_wr_any;
  logic                       irq_any;

  nodestat_decode #(.NODES(NODES)) u_dec (
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .region        (region),
    .idx           (idx),
    .info_wr       (info_wr),
    .err_clr_byte  (err_clr_byte),
    .ien_wr        (ien_wr),
    .iflg_clr_byte (iflg_clr_byte)
  );

  // Byte strobes expanded to per-flag clear masks.
  for (genvar k = 0; k < ERR_BYTES; k++) begin : g_errclr
    assign err_clr[k*BYTE_W +: BYTE_W] = err_clr_byte[k] ? bus_wdata : '0;
  end
  for (genvar k = 0; k < PAIR_BYTES; k++) begin : g_chgclr
    assign iflg_clr[k*BYTE_W +: BYTE_W] = iflg_clr_byte[k] ? bus_wdata : '0;
  end

  nodestat_bytereg #(.BYTES(NODES)) u_info (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (info_wr),
    .wdata_i (bus_wdata),
    .q       (info_q)
  );

  nodestat_bytereg #(.BYTES(PAIR_BYTES)) u_ien (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (ien_wr),
    .wdata_i (bus_wdata),
    .q       (ien_q)
  );

  nodestat_flags #(.W(NODES)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (err_set),
    .clr_i (err_clr),
    .q     (err_q)
  );

  nodestat_flags #(.W(CHG_W)) u_chg (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (chg_set),
    .clr_i (iflg_clr),
    .q     (iflg_q)
  );

  assign ien_wr_any = |ien_wr;
  assign irq_any    = |(iflg_q & ien_q);
  assign irq_n      = ~irq_any;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (region)
        RG_INFO: bus_rdata = info_q[int'(idx)*BYTE_W +: BYTE_W];
        RG_ERR:  bus_rdata = err_q [int'(idx)*BYTE_W +: BYTE_W];
        RG_IEN:  bus_rdata = ien_q [int'(idx)*BYTE_W +: BYTE_W];
        RG_IFLG: bus_rdata = iflg_q[int'(idx)*BYTE_W +: BYTE_W];
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/nodestat_chk.sv
module nodestat_chk
  import nodestat_pkg::*;
#(
  parameter int NODES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [BYTE_W-1:0]      bus_rdata,
  input  region_e                region,
  input  logic                   irq_n,
  input  logic [NODES-1:0]       err_set,
  input  logic [NODES-1:0]       err_q,
  input  logic [NODES-1:0]       err_clr,
  input  logic [NODES*PORTS-1:0] chg_set,
  input  logic [NODES*PORTS-1:0] iflg_q,
  input  logic [NODES*PORTS-1:0] iflg_clr,
  input  logic                   ien_wr_any
);

  // R3, R5, R7: a set pulse always leaves its flag set, even under a clear.
  assert_err_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_q & $past(err_set)) == $past(err_set)));
  assert_chg_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((iflg_q & $past(chg_set)) == $past(chg_set)));

  // R6: a cleared bit without a set drops to 0.
  assert_chg_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((iflg_q & $past(iflg_clr & ~chg_set)) == '0));

  // R9, R10: flags with neither a set nor a clear keep their value.
  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_q & ~$past(err_set | err_clr)) == ($past(err_q) & ~$past(err_set | err_clr))));
  assert_chg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((iflg_q & ~$past(chg_set | iflg_clr)) == ($past(iflg_q) & ~$past(chg_set | iflg_clr))));

  // R8: the request only asserts after a set event or an enable write,
  // and only releases after a flag acknowledge or an enable write.
  assert_irq_fall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(|chg_set) || $past(ien_wr_any)));
  assert_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> ($past(|iflg_clr) || $past(ien_wr_any)));

  // R9: reads outside every area return zero.
  assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && region == RG_NONE) |-> (bus_rdata == '0));

endmodule

bind nodestat_bank nodestat_chk #(.NODES(NODES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_rdata  (bus_rdata),
  .region     (region),
  .irq_n      (irq_n),
  .err_set    (err_set),
  .err_q      (err_q),
  .err_clr    (err_clr),
  .chg_set    (chg_set),
  .iflg_q     (iflg_q),
  .iflg_clr   (iflg_clr),
  .ien_wr_any (ien_wr_any)
);

// File: tb/tb_nodestat_bank.sv
module tb_nodestat_bank;

  localparam int NODES = 64;
  localparam int NPORT = 4;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   bus_sel = 1'b0;
  logic                   bus_wr = 1'b0;
  logic [8:0]             bus_addr = '0;
  logic [7:0]             bus_wdata = '0;
  logic [7:0]             bus_rdata;
  logic [NODES-1:0]       err_set = '0;
  logic [NODES*NPORT-1:0] chg_set = '0;
  logic                   irq_n;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  nodestat_bank #(.NODES(NODES)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .err_set   (err_set),
    .chg_set   (chg_set),
    .irq_n     (irq_n)
  );

  task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic cpu_write(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [8:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic expect_byte(input string req, input logic [8:0] a, input logic [7:0] exp);
    logic [7:0] d;
    cpu_read(a, d);
    check(req, $sformatf("addr %03h", a), d, exp);
  endtask

  task automatic pulse_err(input int node);
    @(negedge clk); err_set[node] = 1'b1;
    @(negedge clk); err_set[node] = 1'b0;
  endtask

  task automatic pulse_chg(input int node, input int port);
    @(negedge clk); chg_set[node*NPORT+port] = 1'b1;
    @(negedge clk); chg_set[node*NPORT+port] = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    expect_byte("R1", 9'h078, 8'h00);
    expect_byte("R1", 9'h0BF, 8'h00);
    expect_byte("R1", 9'h0C0, 8'h00);
    expect_byte("R1", 9'h0FF, 8'h00);
    check("R1", "irq_n", {7'd0, irq_n}, 8'h01);
  endtask

  // R2, R9
  task automatic t_info();
    cpu_write(9'h078, 8'hA5);
    cpu_write(9'h0B7, 8'h3C);
    expect_byte("R2", 9'h078, 8'hA5);
    expect_byte("R2", 9'h0B7, 8'h3C);
    expect_byte("R2", 9'h079, 8'h00);
    cpu_write(9'h077, 8'hFF);
    expect_byte("R9", 9'h077, 8'h00);
    expect_byte("R9", 9'h078, 8'hA5);
  endtask

  // R3, R6, R10
  task automatic t_err();
    pulse_err(10);
    pulse_err(63);
    expect_byte("R3", 9'h0B9, 8'h04);
    expect_byte("R3", 9'h0BF, 8'h80);
    expect_byte("R10", 9'h0B9, 8'h04);
    cpu_write(9'h0B9, 8'h00);
    expect_byte("R6", 9'h0B9, 8'h04);
    cpu_write(9'h0B9, 8'hFB);
    expect_byte("R6", 9'h0B9, 8'h04);
    cpu_write(9'h0B9, 8'h04);
    expect_byte("R6", 9'h0B9, 8'h00);
    expect_byte("R6", 9'h0BF, 8'h80);
  endtask

  // R4, R5, R8
  task automatic t_chg_irq();
    cpu_write(9'h0C1, 8'h5A);
    expect_byte("R4", 9'h0C1, 8'h5A);
    pulse_chg(3, 1);
    expect_byte("R5", 9'h0E1, 8'h20);
    check("R8", "irq_n masked", {7'd0, irq_n}, 8'h01);
    cpu_write(9'h0C1, 8'h20);
    check("R8", "irq_n enabled", {7'd0, irq_n}, 8'h00);
    pulse_chg(2, 3);
    expect_byte("R5", 9'h0E1, 8'h28);
    cpu_write(9'h0E1, 8'h20);
    check("R8", "irq_n acked", {7'd0, irq_n}, 8'h01);
    expect_byte("R6", 9'h0E1, 8'h08);
    cpu_write(9'h0E1, 8'h08);
  endtask

  // R7
  task automatic t_collide();
    pulse_chg(3, 1);
    pulse_chg(3, 2);
    @(negedge clk);
    chg_set[3*NPORT+1] = 1'b1;
    err_set[5] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 9'h0E1; bus_wdata = 8'h60;
    @(negedge clk);
    chg_set[3*NPORT+1] = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0;
    expect_byte("R7", 9'h0E1, 8'h20);
    check("R7", "irq_n held", {7'd0, irq_n}, 8'h00);
    @(negedge clk);
    err_set[5] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 9'h0B8; bus_wdata = 8'h20;
    @(negedge clk);
    err_set[5] = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0;
    expect_byte("R7", 9'h0B8, 8'h20);
  endtask

  // R9
  task automatic t_holes();
    cpu_write(9'h008, 8'hFF);
    cpu_write(9'h150, 8'hFF);
    expect_byte("R9", 9'h008, 8'h00);
    expect_byte("R9", 9'h150, 8'h00);
    expect_byte("R9", 9'h000, 8'h00);
    expect_byte("R9", 9'h0C1, 8'h20);
    expect_byte("R9", 9'h0E1, 8'h20);
  endtask

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_info();
    t_err();
    t_chg_irq();
    t_collide();
    t_holes();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule